// File: doc/BRIEF.md
# Thermal and Overcurrent Fault Supervisor

This block watches the health of a two-channel switching audio power stage. It receives the die temperature as an unsigned integer in degrees Celsius, already digitised. It also receives one overcurrent flag for each of the four bridge legs. From these it drives three active-low error outputs: thermal warning, thermal shutdown and overcurrent. It also raises a shutdown request and a mute request toward the rest of the amplifier.

The two thermal errors trip at different temperatures. Both are released at one shared point that lies well below either trip point, so the outputs do not chatter near a threshold. The overcurrent error works differently: it is sticky. Once set, it stays set until one of two things happens. The first is a synchronous reset. The second is a full mute cycle: the mute input goes low and then returns high while no leg still reports overcurrent. The leg flags pass through a two-flop synchroniser before use. The mute input is assumed to be synchronous to the block clock.

Top module: `fault_supervisor`

## Requirements
- R1: The warning error `warn_err_n` goes low one clock after `die_temp` is strictly above 135. A value of exactly 135 does not trip it.
- R2: The shutdown error `stop_err_n` goes low and `shutdown_req` goes high one clock after `die_temp` is strictly above 150. A value of exactly 150 does not trip them.
- R3: Once tripped, the thermal errors and `shutdown_req` hold for any temperature from 120 up. All three release in the same clock, one clock after `die_temp` is below 120. After a release, a temperature of 135 or less does not re-trip them.
- R4: A high level on any bit of `leg_oc` (one bit per bridge leg, bits 0 to 3) drives `oc_err_n` low and `mute_req` high exactly three clocks later: two synchroniser stages plus the latch.
- R5: The overcurrent error stays latched after every leg flag has dropped. Holding `mute_n` low alone does not clear it.
- R6: When `mute_n` returns high after having been low, and no synchronised leg flag is present, `oc_err_n` returns high and `mute_req` returns low one clock after the rising edge of `mute_n`.
- R7: If a synchronised leg flag is still present at the clock where `mute_n` returns high, the overcurrent error stays asserted.
- R8: While `rst_n` is low at a clock edge, all error outputs go high and both requests go low. The synchroniser stages are cleared as well.
- R9: Thermal faults never assert `oc_err_n` or `mute_req`, and an overcurrent fault never asserts the thermal errors or `shutdown_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mute_n | input | 1 | Active-low mute input, synchronous to clk |
| die_temp | input | 8 | Die temperature, unsigned, degrees C |
| leg_oc | input | 4 | Per-leg overcurrent flags, asynchronous |
| warn_err_n | output | 1 | Thermal warning error, active low |
| stop_err_n | output | 1 | Thermal shutdown error, active low |
| oc_err_n | output | 1 | Overcurrent error, active low |
| shutdown_req | output | 1 | Request to shut the power stage down |
| mute_req | output | 1 | Request to mute the power stage |

## Verification
Each result has a fixed latency. A temperature change is seen on the thermal outputs one clock later. A leg flag reaches `oc_err_n` and `mute_req` three clocks later. A rising `mute_n` clears the latch one clock later, and a reset clears everything one clock later. The bench drives every input one time unit after a rising edge, advances exactly the required number of edges, and samples just after that edge. For the overcurrent path it also checks one clock earlier, to pin the latency from both sides. The boundary temperatures 135, 150 and 120 are each checked on both sides of their threshold.

// File: rtl/fsup_pkg.sv
// Package: shared types for the fault supervisor.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package fsup_pkg;

    // Registered thermal fault state; stop implies warn.
    typedef struct packed {
        logic stop;
        logic warn;
    } therm_flags_t;

endpackage

// File: rtl/fsup_sync.sv
// Module: multi-stage synchroniser for a vector of independent flags.
// Assumes each bit is a level that lasts longer than STAGES clocks; no
// pulse stretching or bus coherency is provided.
module fsup_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw flags through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/fsup_thermal.sv
// Module: thermal fault detector with a shared hysteretic release.
// Assumes RELEASE_LVL < WARN_TRIP < STOP_TRIP, all representable in TEMP_W.
// Both flags trip on "strictly above" and clear together on "strictly below".
module fsup_thermal
    import fsup_pkg::*;
#(
    parameter int TEMP_W      = 8,
    parameter int WARN_TRIP   = 135,
    parameter int STOP_TRIP   = 150,
    parameter int RELEASE_LVL = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] die_temp,
    output therm_flags_t      flags_q
);

    localparam logic [TEMP_W-1:0] WARN_LVL = TEMP_W'(WARN_TRIP);
    localparam logic [TEMP_W-1:0] STOP_LVL = TEMP_W'(STOP_TRIP);
    localparam logic [TEMP_W-1:0] REL_LVL  = TEMP_W'(RELEASE_LVL);

    logic over_warn;
    logic over_stop;
    logic below_rel;

    // Compare the temperature with the three levels.
    always_comb begin
        over_warn = die_temp > WARN_LVL;
        over_stop = die_temp > STOP_LVL;
        below_rel = die_temp < REL_LVL;
    end

    // Set each flag on its trip, clear both on the shared release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (below_rel) begin
            flags_q <= '0;
        end else begin
            if (over_warn) flags_q.warn <= 1'b1;
            if (over_stop) flags_q.stop <= 1'b1;
        end
    end

    assert_warn_trip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (die_temp > WARN_LVL) |=> flags_q.warn);

    assert_stop_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (die_temp > STOP_LVL) |=> (flags_q.stop && flags_q.warn));

    assert_band_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.stop && die_temp >= REL_LVL) |=> flags_q.stop);

    assert_joint_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (die_temp < REL_LVL) |=> (!flags_q.warn && !flags_q.stop));

endmodule

// File: rtl/fsup_oc_latch.sv
// Module: sticky overcurrent latch.
// Set by any synchronised leg flag; cleared only by reset or by mute_n
// rising after a low period with no flag present. mute_n is assumed
// synchronous to clk. Setting wins over clearing.
module fsup_oc_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mute_n,
    input  logic oc_any,
    output logic oc_q
);

    logic mute_prev_q;
    logic mute_negated;

    // Detect the end of a mute period.
    always_comb begin
        mute_negated = mute_n && !mute_prev_q;
    end

    // Hold the previous mute level and update the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_prev_q <= 1'b1;
            oc_q        <= 1'b0;
        end else begin
            mute_prev_q <= mute_n;
            if (oc_any) begin
                oc_q <= 1'b1;
            end else if (mute_negated) begin
                oc_q <= 1'b0;
            end
        end
    end

    assert_oc_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oc_any |=> oc_q);

    assert_oc_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_q && !(mute_n && !mute_prev_q)) |=> oc_q);

    assert_oc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_n && !mute_prev_q && !oc_any) |=> !oc_q);

    assert_oc_relatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_n && !mute_prev_q && oc_any) |=> oc_q);

endmodule

// File: rtl/fault_supervisor.sv
// Module: top of the thermal and overcurrent fault supervisor.
// Synchronises each leg flag, ORs them into a sticky latch, runs the
// thermal hysteresis and maps the state onto active-low error outputs.
// Assumes die_temp is already synchronous and stable for a clock.
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int TEMP_W      = 8,
    parameter int NUM_LEGS    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int WARN_TRIP   = 135,
    parameter int STOP_TRIP   = 150,
    parameter int RELEASE_LVL = 120
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mute_n,
    input  logic [TEMP_W-1:0]   die_temp,
    input  logic [NUM_LEGS-1:0] leg_oc,
    output logic                warn_err_n,
    output logic                stop_err_n,
    output logic                oc_err_n,
    output logic                shutdown_req,
    output logic                mute_req
);

    logic [NUM_LEGS-1:0] leg_sync;
    logic                oc_any;
    logic                oc_q;
    therm_flags_t        therm_q;

    // One synchroniser per bridge leg.
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        fsup_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) sync_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (leg_oc[g]),
            .sync_out (leg_sync[g])
        );
    end

    // Merge the synchronised leg flags.
    always_comb begin
        oc_any = |leg_sync;
    end

    fsup_oc_latch oc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mute_n (mute_n),
        .oc_any (oc_any),
        .oc_q   (oc_q)
    );

    fsup_thermal #(
        .TEMP_W      (TEMP_W),
        .WARN_TRIP   (WARN_TRIP),
        .STOP_TRIP   (STOP_TRIP),
        .RELEASE_LVL (RELEASE_LVL)
    ) therm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .die_temp (die_temp),
        .flags_q  (therm_q)
    );

    // Map the internal state onto the outputs.
    always_comb begin
        warn_err_n   = !therm_q.warn;
        stop_err_n   = !therm_q.stop;
        shutdown_req = therm_q.stop;
        oc_err_n     = !oc_q;
        mute_req     = oc_q;
    end

    assert_reset_clean_R8: assert property (@(posedge clk)
        !rst_n |=> (warn_err_n && stop_err_n && oc_err_n && !shutdown_req && !mute_req));

    assert_oc_from_legs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!oc_any && !oc_q) |=> !mute_req);

endmodule

// File: tb/fault_supervisor_tb.sv
// Bench: directed scenarios for the fault supervisor, one task each.
module fault_supervisor_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mute_n;
    logic [7:0] die_temp;
    logic [3:0] leg_oc;
    logic       warn_err_n, stop_err_n, oc_err_n, shutdown_req, mute_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fault_supervisor dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mute_n       (mute_n),
        .die_temp     (die_temp),
        .leg_oc       (leg_oc),
        .warn_err_n   (warn_err_n),
        .stop_err_n   (stop_err_n),
        .oc_err_n     (oc_err_n),
        .shutdown_req (shutdown_req),
        .mute_req     (mute_req)
    );

    // Advance n rising edges, then settle one time unit past the edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic w, input logic s, input logic o,
                             input logic sd, input logic mr);
        check(req, "warn_err_n", warn_err_n, w);
        check(req, "stop_err_n", stop_err_n, s);
        check(req, "oc_err_n", oc_err_n, o);
        check(req, "shutdown_req", shutdown_req, sd);
        check(req, "mute_req", mute_req, mr);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0; mute_n = 1'b1; die_temp = 8'd25; leg_oc = '0;
        step(3);
        check_all("R8", 1, 1, 1, 0, 0);
        rst_n = 1'b1;
        step(2);
        check_all("R8", 1, 1, 1, 0, 0);
    endtask

    task automatic t_warn_trip();
        die_temp = 8'd135; step(1);
        check("R1", "warn at 135", warn_err_n, 1'b1);
        die_temp = 8'd136; step(1);
        check("R1", "warn at 136", warn_err_n, 1'b0);
        check("R1", "stop at 136", stop_err_n, 1'b1);
    endtask

    task automatic t_stop_trip();
        die_temp = 8'd150; step(1);
        check("R2", "stop at 150", stop_err_n, 1'b1);
        check("R2", "shutdown at 150", shutdown_req, 1'b0);
        die_temp = 8'd151; step(1);
        check("R2", "stop at 151", stop_err_n, 1'b0);
        check("R2", "shutdown at 151", shutdown_req, 1'b1);
        check("R9", "oc_err_n under thermal", oc_err_n, 1'b1);
        check("R9", "mute_req under thermal", mute_req, 1'b0);
    endtask

    task automatic t_hysteresis();
        die_temp = 8'd140; step(1);
        check_all("R3", 0, 0, 1, 1, 0);
        die_temp = 8'd120; step(2);
        check_all("R3", 0, 0, 1, 1, 0);
        die_temp = 8'd119; step(1);
        check_all("R3", 1, 1, 1, 0, 0);
        die_temp = 8'd135; step(2);
        check("R3", "no re-trip at 135", warn_err_n, 1'b1);
        die_temp = 8'd25; step(1);
    endtask

    task automatic t_oc_latch();
        leg_oc = 4'b0100; step(2);
        check("R4", "oc_err_n before latency", oc_err_n, 1'b1);
        step(1);
        check("R4", "oc_err_n after 3", oc_err_n, 1'b0);
        check("R4", "mute_req after 3", mute_req, 1'b1);
        check("R9", "warn under oc", warn_err_n, 1'b1);
        check("R9", "shutdown under oc", shutdown_req, 1'b0);
        leg_oc = '0; step(5);
        check("R5", "held after flag drop", oc_err_n, 1'b0);
        mute_n = 1'b0; step(3);
        check("R5", "held during mute", oc_err_n, 1'b0);
        mute_n = 1'b1; step(1);
        check("R6", "oc_err_n after mute cycle", oc_err_n, 1'b1);
        check("R6", "mute_req after mute cycle", mute_req, 1'b0);
    endtask

    task automatic t_relatch();
        leg_oc = 4'b0001; step(3);
        check("R4", "leg0 latch", oc_err_n, 1'b0);
        mute_n = 1'b0; step(1);
        mute_n = 1'b1; step(1);
        check("R7", "relatched with flag", oc_err_n, 1'b0);
        step(2);
        check("R7", "still latched", mute_req, 1'b1);
        leg_oc = '0; step(3);
        mute_n = 1'b0; step(1);
        mute_n = 1'b1; step(1);
        check("R6", "clear after flag gone", oc_err_n, 1'b1);
    endtask

    task automatic t_reset_clears();
        die_temp = 8'd160; leg_oc = 4'b1000; step(4);
        check_all("R8", 0, 0, 0, 1, 1);
        rst_n = 1'b0; die_temp = 8'd25; leg_oc = '0; step(1);
        check_all("R8", 1, 1, 1, 0, 0);
        rst_n = 1'b1; step(4);
        check_all("R8", 1, 1, 1, 0, 0);
    endtask

    initial begin
        t_reset_state();
        t_warn_trip();
        t_stop_trip();
        t_hysteresis();
        t_oc_latch();
        t_relatch();
        t_reset_clears();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule